// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

A passive observer for a single-data-rate SDRAM command bus. It samples the clock-enable, chip-select, row/column strobes, write-enable, bank-select and address pins on every rising clock edge. From them it decodes one command per cycle, keeps an open/closed state and the open row for each bank, and measures the spacing between commands with small countdown windows. When a command breaks a protocol or spacing rule, it raises a one-cycle error pulse with a 4-bit code that names the broken rule.

The monitor drives nothing onto the bus. It is placed beside a memory controller in a testbench, connected to the same pins the memory sees, and its error pulse is counted or logged. All spacing limits are parameters in clock cycles. The integration converts the nanosecond limits of the speed grade in use into clock counts at the bus clock. The monitor keeps checking after any error, so one run can report several violations.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only in a cycle with `cke_i`=1 and `cs_n_i`=0. The strobes {`ras_n_i`,`cas_n_i`,`we_n_i`} select the command: 011 open row, 101 read, 100 write, 010 close (precharge), 001 auto refresh, 000 mode-register load. Every other cycle, including 111 and 110, counts as an idle cycle.
- R2: An open-row command to a closed bank marks the bank open. The bank's bit in `bank_active_o` shows this in the cycle after the edge, and `addr_i` appears as that bank's row in `bank_row_o` (bank b at bits b*ADDR_W upward). A close command clears the bank's bit. A close command with `addr_i[AP_BIT]`=1 clears every bank.
- R3: After the edge that samples a violation, `err_o` is high for exactly that one following cycle with a nonzero `err_code_o`. In cycles with no violation, `err_o` is 0 and `err_code_o` is 0. Checking continues after an error.
- R4: A read or write to a closed bank gives code 1.
- R5: An open-row command to a bank that is already open gives code 2 and leaves that bank's state and row unchanged.
- R6: A close command that reaches an open bank fewer than T_RAS cycles after that bank was opened gives code 3. This applies to a single-bank close and to a close-all. A close command to a closed bank is not an error.
- R7: An open-row command to a bank other than the previous open-row command's bank, fewer than T_RRD cycles after it, gives code 4.
- R8: An open-row command fewer than T_RFC cycles after an auto refresh gives code 5.
- R9: Any command other than an idle cycle fewer than T_MRD cycles after a mode-register load gives code 6.
- R10: Reads and writes to open banks on consecutive cycles give no error.
- R11: When REF_INTERVAL edges pass without an auto refresh, code 7 is given. The count restarts from that edge, so the flag repeats every REF_INTERVAL edges until a refresh arrives. A refresh restarts the count.
- R12: When several command rules break on one edge, the lowest code is reported. When the refresh deadline falls on an edge with a command violation, the command code is reported, and code 7 follows on the next edge that has no command violation.
- R13: After reset, all banks are closed, `err_o` and `err_code_o` are 0, and the refresh count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge samples |
| rst_ni | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Bus clock enable |
| cs_n_i | input | 1 | Chip select, low active |
| ras_n_i | input | 1 | Row strobe, low active |
| cas_n_i | input | 1 | Column strobe, low active |
| we_n_i | input | 1 | Write enable, low active |
| ba_i | input | BA_W | Bank select |
| addr_i | input | ADDR_W | Address bus (row on open, close-all flag at AP_BIT) |
| err_o | output | 1 | One-cycle violation pulse |
| err_code_o | output | 4 | Violation code, 0 when no violation |
| bank_active_o | output | NUM_BANKS | Open flag per bank |
| bank_row_o | output | NUM_BANKS*ADDR_W | Open row per bank |

## Verification
Two functions can meet on one edge: the refresh deadline expiring and a command that breaks a bus rule. The bench provokes this by counting idle cycles after a refresh and placing a read to a closed bank exactly on the deadline edge. It judges the outcome as code 1 in that cycle and code 7 in the next. Several command rules can also break together; an open-row command issued just after a refresh and within the bank-to-bank window must report code 4 rather than 5. Each spacing rule is swept over every distance from one cycle to one past its limit, with the expected code derived from the distance alone.

// File: rtl/sdrmon_pkg.sv
`timescale 1ns/1ps
package sdrmon_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_LMR
  } cmd_e;

  localparam logic [3:0] ERR_NONE        = 4'd0;
  localparam logic [3:0] ERR_IDLE_ACCESS = 4'd1;
  localparam logic [3:0] ERR_ACT_OPEN    = 4'd2;
  localparam logic [3:0] ERR_RAS         = 4'd3;
  localparam logic [3:0] ERR_RRD         = 4'd4;
  localparam logic [3:0] ERR_RFC         = 4'd5;
  localparam logic [3:0] ERR_MRD         = 4'd6;
  localparam logic [3:0] ERR_REF_LATE    = 4'd7;
endpackage

// File: rtl/sdrmon_decode.sv
`timescale 1ns/1ps
module sdrmon_decode
  import sdrmon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  // R1: only selected, clock-enabled cycles carry a command
  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_i && !cs_n_i) begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_LMR;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdrmon_gap.sv
`timescale 1ns/1ps
module sdrmon_gap #(
  parameter int GAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  // Window of GAP-1 cycles after the loading edge
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= CW'(GAP - 1);
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // Covers the spacing windows of R6, R7, R8 and R9
  generate
    if (GAP > 1) begin : g_chk
      p_gap_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> busy_o);
      p_gap_drains_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !busy_o) |=> !busy_o);
    end
  endgenerate
endmodule

// File: rtl/sdrmon_bank.sv
`timescale 1ns/1ps
module sdrmon_bank #(
  parameter int ADDR_W = 12,
  parameter int T_RAS  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic [ADDR_W-1:0] row_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] row_o,
  output logic              ras_busy_o
);
  logic open_now;
  assign open_now = act_i && !active_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end else if (open_now) begin
      active_o <= 1'b1;
      row_o    <= row_i;
    end else if (pre_i) begin
      active_o <= 1'b0;
    end
  end

  sdrmon_gap #(.GAP(T_RAS)) ras_win_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (open_now),
    .busy_o (ras_busy_o)
  );

  p_open_sets_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !active_o) |=> (active_o && row_o == $past(row_i)));
  p_close_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !act_i) |=> !active_o);
  p_reopen_keeps_row_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && active_o && !pre_i) |=> (active_o && $stable(row_o)));
endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdrmon_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ADDR_W       = 12,
  parameter int AP_BIT       = 10,
  parameter int T_RAS        = 6,
  parameter int T_RRD        = 2,
  parameter int T_RFC        = 8,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 2080,
  localparam int BA_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cke_i,
  input  logic                        cs_n_i,
  input  logic                        ras_n_i,
  input  logic                        cas_n_i,
  input  logic                        we_n_i,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        err_o,
  output logic [3:0]                  err_code_o,
  output logic [NUM_BANKS-1:0]        bank_active_o,
  output logic [NUM_BANKS*ADDR_W-1:0] bank_row_o
);
  localparam int RW = $clog2(REF_INTERVAL + 1);

  cmd_e cmd_c;
  logic [NUM_BANKS-1:0] sel_c, pre_c, ras_busy;
  logic cur_open, rrd_busy, rfc_busy, mrd_busy, is_act, is_col;
  logic [BA_W-1:0] last_ba_q;
  logic [RW-1:0]   ref_cnt_q;
  logic late_hit, late_now, late_pend_q;
  logic [3:0] cmd_code, next_code;

  sdrmon_decode dec_i (
    .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .cmd_o(cmd_c)
  );

  assign is_act = (cmd_c == CMD_ACT);
  assign is_col = (cmd_c == CMD_RD) || (cmd_c == CMD_WR);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign sel_c[b] = (ba_i == BA_W'(b));
      assign pre_c[b] = (cmd_c == CMD_PRE) && (sel_c[b] || addr_i[AP_BIT]);
      sdrmon_bank #(.ADDR_W(ADDR_W), .T_RAS(T_RAS)) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .act_i      (is_act && sel_c[b]),
        .pre_i      (pre_c[b]),
        .row_i      (addr_i),
        .active_o   (bank_active_o[b]),
        .row_o      (bank_row_o[b*ADDR_W +: ADDR_W]),
        .ras_busy_o (ras_busy[b])
      );
    end
  endgenerate

  assign cur_open = |(sel_c & bank_active_o);

  sdrmon_gap #(.GAP(T_RRD)) rrd_win_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_act), .busy_o(rrd_busy));
  sdrmon_gap #(.GAP(T_RFC)) rfc_win_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd_c == CMD_REF), .busy_o(rfc_busy));
  sdrmon_gap #(.GAP(T_MRD)) mrd_win_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd_c == CMD_LMR), .busy_o(mrd_busy));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     last_ba_q <= '0;
    else if (is_act) last_ba_q <= ba_i;
  end

  // R12: lowest code wins among rules broken by one command
  always_comb begin
    cmd_code = ERR_NONE;
    if (is_col && !cur_open)                             cmd_code = ERR_IDLE_ACCESS;
    else if (is_act && cur_open)                         cmd_code = ERR_ACT_OPEN;
    else if (|(pre_c & ras_busy & bank_active_o))        cmd_code = ERR_RAS;
    else if (is_act && rrd_busy && ba_i != last_ba_q)    cmd_code = ERR_RRD;
    else if (is_act && rfc_busy)                         cmd_code = ERR_RFC;
    else if (cmd_c != CMD_NOP && mrd_busy)               cmd_code = ERR_MRD;
  end

  // R11: refresh deadline, restarting on refresh or on expiry
  assign late_hit = (ref_cnt_q == RW'(REF_INTERVAL - 1)) && (cmd_c != CMD_REF);
  assign late_now = late_hit || late_pend_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                  ref_cnt_q <= '0;
    else if (cmd_c == CMD_REF)    ref_cnt_q <= '0;
    else if (late_hit)            ref_cnt_q <= '0;
    else                          ref_cnt_q <= ref_cnt_q + 1'b1;
  end

  assign next_code = (cmd_code != ERR_NONE) ? cmd_code :
                     (late_now ? ERR_REF_LATE : ERR_NONE);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      late_pend_q <= 1'b0;
      err_o       <= 1'b0;
      err_code_o  <= ERR_NONE;
    end else begin
      late_pend_q <= late_now && (cmd_code != ERR_NONE);
      err_o       <= (next_code != ERR_NONE);
      err_code_o  <= next_code;
    end
  end

  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o >= 4'd1 && err_code_o <= 4'd7));
  p_idle_access_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_col && !cur_open) |=> (err_o && err_code_o == ERR_IDLE_ACCESS));
  p_late_reported_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_hit && cmd_code == ERR_NONE) |=> (err_code_o == ERR_REF_LATE));
  p_late_deferred_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_now && cmd_code != ERR_NONE) |=> (err_code_o != ERR_REF_LATE));
  generate
    if (T_MRD >= 2) begin : g_mrd_chk
      p_mode_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cmd_c == CMD_LMR) && cmd_c != CMD_NOP) |=> err_o);
    end
  endgenerate
endmodule

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;
  localparam int NB = 4, AW = 12, TRAS = 5, TRRD = 3, TRFC = 6, TMRD = 2, RI = 60;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001,
                         C_LMR = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  logic err;
  logic [3:0] code;
  logic [NB-1:0] act_v;
  logic [NB*AW-1:0] rows;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor #(.NUM_BANKS(NB), .ADDR_W(AW), .AP_BIT(10), .T_RAS(TRAS),
    .T_RRD(TRRD), .T_RFC(TRFC), .T_MRD(TMRD), .REF_INTERVAL(RI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .err_o(err),
    .err_code_o(code), .bank_active_o(act_v), .bank_row_o(rows));

  task automatic chk_code(int exp, string req);
    checks++;
    if (err !== (exp != 0) || code !== exp[3:0]) begin
      fails++;
      $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d",
               req, err, code, exp != 0, exp);
    end
  endtask

  task automatic chk_bank(logic [NB-1:0] exp_v, int b, int exp_row, string req);
    checks++;
    if (act_v !== exp_v || (exp_row >= 0 && rows[b*AW +: AW] !== exp_row[AW-1:0])) begin
      fails++;
      $display("FAIL %s: active=%b row=%h expected active=%b row=%h",
               req, act_v, rows[b*AW +: AW], exp_v, exp_row);
    end
  endtask

  task automatic raw(logic c, logic s, logic [2:0] rcw, int b, int a, int exp, string req);
    cke = c; cs_n = s; {ras_n, cas_n, we_n} = rcw; ba = b[1:0]; addr = a[AW-1:0];
    @(posedge clk); @(negedge clk);
    chk_code(exp, req);
  endtask

  task automatic step(logic [2:0] rcw, int b, int a, int exp, string req);
    raw(1'b1, 1'b0, rcw, b, a, exp, req);
  endtask

  task automatic nops(int n, string req);
    for (int i = 0; i < n; i++) step(C_NOP, 0, 0, 0, req);
  endtask

  task automatic settle();
    step(C_REF, 0, 0, 0, "R8");
    nops(TRFC, "R8");
  endtask

  task automatic close_all();
    nops(TRAS, "R6");
    step(C_PRE, 0, 1 << 10, 0, "R6");
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; ba = '0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_code(0, "R13");
    chk_bank('0, 0, -1, "R13");
    rst_n = 1'b1;

    // R1, R2, R5, R10
    settle();
    step(C_ACT, 2, 'h5A3, 0, "R2");
    chk_bank(4'b0100, 2, 'h5A3, "R2");
    step(C_ACT, 2, 'h111, 2, "R5");
    chk_bank(4'b0100, 2, 'h5A3, "R5");
    raw(1'b0, 1'b0, C_ACT, 1, 'h222, 0, "R1");
    raw(1'b1, 1'b1, C_ACT, 1, 'h222, 0, "R1");
    raw(1'b1, 1'b0, 3'b110, 1, 'h222, 0, "R1");
    chk_bank(4'b0100, 2, 'h5A3, "R1");
    step(C_ACT, 1, 'h0AB, 0, "R2");
    chk_bank(4'b0110, 1, 'h0AB, "R2");
    step(C_RD, 1, 0, 0, "R10");
    step(C_WR, 1, 4, 0, "R10");
    step(C_RD, 2, 8, 0, "R10");
    step(C_WR, 2, 9, 0, "R10");
    close_all();
    chk_bank('0, 0, -1, "R2");
    step(C_RD, 3, 0, 1, "R4");
    step(C_WR, 0, 0, 1, "R4");

    // R6 sweep on one bank
    for (int g = 1; g <= TRAS + 1; g++) begin
      settle();
      step(C_ACT, 0, g, 0, "R6");
      nops(g - 1, "R6");
      step(C_PRE, 0, 0, (g < TRAS) ? 3 : 0, "R6");
      chk_bank('0, 0, -1, "R6");
    end
    step(C_PRE, 3, 0, 0, "R6");
    settle();
    step(C_ACT, 0, 1, 0, "R6");
    nops(TRAS, "R6");
    step(C_ACT, 1, 2, 0, "R6");
    step(C_PRE, 0, 1 << 10, 3, "R6");
    chk_bank('0, 0, -1, "R6");

    // R7 sweep
    for (int g = 1; g <= TRRD + 1; g++) begin
      settle();
      step(C_ACT, 0, 3, 0, "R7");
      nops(g - 1, "R7");
      step(C_ACT, 1, 4, (g < TRRD) ? 4 : 0, "R7");
      chk_bank(4'b0011, 1, 4, "R7");
      close_all();
    end

    // R8 sweep
    for (int g = 1; g <= TRFC + 1; g++) begin
      settle();
      step(C_REF, 0, 0, 0, "R8");
      nops(g - 1, "R8");
      step(C_ACT, 2, 5, (g < TRFC) ? 5 : 0, "R8");
      close_all();
    end

    // R9 sweep, deselect counts as idle
    for (int g = 1; g <= TMRD + 1; g++) begin
      settle();
      step(C_LMR, 0, 'h32, 0, "R9");
      nops(g - 1, "R9");
      step(C_PRE, 3, 0, (g < TMRD) ? 6 : 0, "R9");
    end
    settle();
    step(C_LMR, 0, 'h32, 0, "R9");
    raw(1'b1, 1'b1, C_RD, 0, 0, 0, "R9");

    // R12: coincident command rules
    settle();
    step(C_LMR, 0, 0, 0, "R12");
    step(C_RD, 1, 0, 1, "R12");
    settle();
    step(C_ACT, 0, 7, 0, "R12");
    step(C_REF, 0, 0, 0, "R12");
    step(C_ACT, 1, 8, 4, "R12");
    close_all();

    // R11 deadline and R12 deferral
    step(C_REF, 0, 0, 0, "R11");
    nops(RI - 1, "R11");
    step(C_NOP, 0, 0, 7, "R11");
    nops(RI - 1, "R11");
    step(C_NOP, 0, 0, 7, "R11");
    nops(RI - 1, "R12");
    step(C_RD, 0, 0, 1, "R12");
    step(C_NOP, 0, 0, 7, "R12");
    step(C_REF, 0, 0, 0, "R11");
    nops(RI - 1, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule